// File: doc/BRIEF.md
# Byte-Wide Host Read Shadow Bridge

This block lets a host processor with an 8-bit data bus read a bank of 32-bit internal registers. The contents of these registers can change on every core clock. Reading a 32-bit value as four separate bytes would give a torn value. To avoid this, the bridge keeps a 32-bit shadow copy. One host address line acts as a snapshot request. When it is high during a read, the addressed live register is copied into the shadow. The host then reads the shadow out byte by byte, in any order.

The host address has three fields. The two lowest bits choose a byte lane of the shadow. The next six bits name one of 64 internal registers. The top bit is the snapshot request. Byte selection is purely combinational. A host can therefore hold the read strobe and step the lane bits through 0 to 3 to stream a whole quadlet in one long read cycle.

A build option adds automatic update. With it, any read of lane 0 takes a snapshot, so sequential quadlet reads need no explicit request bit.

Top module: `quad_read_bridge`

## Requirements
- R1: Synchronous reset clears the shadow to zero. After reset, reads with the request bit low return 0x00 on every lane.
- R2: While `host_rd` is low, `host_dout` is 0x00. An asserted request bit without a read takes no snapshot.
- R3: A read with `host_addr[8]` high stores live register `host_addr[7:2]` into the shadow at the clock edge that ends the cycle. During that same cycle, `host_dout` already shows the selected byte of the live value.
- R4: Lane order is big-endian: lane 0 is bits 31:24, lane 1 is bits 23:16, lane 2 is bits 15:8 and lane 3 is bits 7:0.
- R5: While a read is held, a change of `host_addr[1:0]` changes `host_dout` in the same cycle to the new lane of the shadow, and takes no snapshot.
- R6: After a snapshot, later reads return bytes of the captured value, even while the live register keeps changing.
- R7: Reads with the request bit low do not change the shadow, whatever the register-index bits are. This holds for any lane order and any number of repeats.
- R8: Host address 0x156 takes a snapshot of register 21 and returns its lane 2.
- R9: With `AUTO_UPDATE` = 1, a read of lane 0 takes a snapshot even when the request bit is low, and reads of lanes 1 to 3 do not. With `AUTO_UPDATE` = 0, a lane 0 read with the request bit low takes no snapshot.
- R10: Holding the request bit high across consecutive read cycles takes a fresh snapshot on every one of those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 9 | Bit 8 snapshot request, bits 7:2 register index, bits 1:0 byte lane |
| host_rd | input | 1 | Host read strobe |
| core_regs | input | 2048 | Live register bank, register n in bits 32n+31:32n |
| host_dout | output | 8 | Host read data |

## Verification
Two functions can fall in the same cycle: taking a snapshot and delivering a byte. During a request cycle, the output must already carry the byte of the live word that is about to be stored, and not the old shadow. The bench provokes this by moving every live register on each clock, so every byte differs from cycle to cycle. It then issues request reads and follows each one at once with lane reads. The bench judges the request cycle against the live value seen in that cycle, and judges the following lane reads against that same value, never against the newer live contents. Held request bits, the automatic lane-0 variant and the single-byte address form cover the other coincidences.

// File: rtl/qrb_pkg.sv
package qrb_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_HOLD = 2'd1,
        CAP_LINE = 2'd2,
        CAP_AUTO = 2'd3
    } cap_kind_t;

    function automatic logic kind_is_capture(cap_kind_t k);
        return (k == CAP_LINE) || (k == CAP_AUTO);
    endfunction

    function automatic logic kind_is_active(cap_kind_t k);
        return k != CAP_IDLE;
    endfunction

endpackage

// File: rtl/qrb_decode.sv
module qrb_decode
    import qrb_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int LANE_W      = 2,
    parameter int AUTO_UPDATE = 0,
    localparam int ADDR_W     = IDX_W + LANE_W + 1
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [LANE_W-1:0] lane,
    output cap_kind_t         kind
);

    assign reg_idx = host_addr[LANE_W +: IDX_W];
    assign lane    = host_addr[LANE_W-1:0];

    always_comb begin
        kind = CAP_IDLE;
        if (host_rd) begin
            if (host_addr[ADDR_W-1]) begin
                kind = CAP_LINE;
            end else if ((AUTO_UPDATE != 0) && (lane == '0)) begin
                kind = CAP_AUTO;
            end else begin
                kind = CAP_HOLD;
            end
        end
    end

endmodule

// File: rtl/qrb_snapshot.sv
module qrb_snapshot
    import qrb_pkg::*;
#(
    parameter int REG_COUNT = 64,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [REG_COUNT*WORD_W-1:0] core_regs,
    input  logic [IDX_W-1:0]            reg_idx,
    input  cap_kind_t                   kind,
    output logic [WORD_W-1:0]           shadow_q,
    output logic [WORD_W-1:0]           view_word
);

    logic [WORD_W-1:0] bank [REG_COUNT];
    logic [WORD_W-1:0] live_word;
    logic              take;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_unpack
        assign bank[g] = core_regs[g*WORD_W +: WORD_W];
    end

    assign live_word = bank[reg_idx];
    assign take      = kind_is_capture(kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (take) begin
            shadow_q <= live_word;
        end
    end

    assign view_word = take ? live_word : shadow_q;

endmodule

// File: rtl/qrb_lane_mux.sv
module qrb_lane_mux
    import qrb_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int BYTE_W   = 8,
    localparam int LANE_N  = WORD_W / BYTE_W,
    localparam int LANE_W  = $clog2(LANE_N)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    input  cap_kind_t         kind,
    output logic [BYTE_W-1:0] dout
);

    logic [BYTE_W-1:0] lanes [LANE_N];

    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        assign lanes[g] = word[WORD_W-1-g*BYTE_W -: BYTE_W];
    end

    assign dout = kind_is_active(kind) ? lanes[lane] : '0;

endmodule

// File: rtl/quad_read_bridge.sv
module quad_read_bridge
    import qrb_pkg::*;
#(
    parameter int REG_COUNT   = 64,
    parameter int WORD_W      = 32,
    parameter int BYTE_W      = 8,
    parameter int AUTO_UPDATE = 0,
    localparam int IDX_W      = $clog2(REG_COUNT),
    localparam int LANE_N     = WORD_W / BYTE_W,
    localparam int LANE_W     = $clog2(LANE_N),
    localparam int ADDR_W     = IDX_W + LANE_W + 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic                        host_rd,
    input  logic [REG_COUNT*WORD_W-1:0] core_regs,
    output logic [BYTE_W-1:0]           host_dout
);

    logic [IDX_W-1:0]  reg_idx;
    logic [LANE_W-1:0] lane;
    cap_kind_t         kind;
    logic [WORD_W-1:0] shadow_q;
    logic [WORD_W-1:0] view_word;

    qrb_decode #(
        .IDX_W      (IDX_W),
        .LANE_W     (LANE_W),
        .AUTO_UPDATE(AUTO_UPDATE)
    ) u_decode (
        .host_addr(host_addr),
        .host_rd  (host_rd),
        .reg_idx  (reg_idx),
        .lane     (lane),
        .kind     (kind)
    );

    qrb_snapshot #(
        .REG_COUNT(REG_COUNT),
        .WORD_W   (WORD_W)
    ) u_snap (
        .clk      (clk),
        .rst      (rst),
        .core_regs(core_regs),
        .reg_idx  (reg_idx),
        .kind     (kind),
        .shadow_q (shadow_q),
        .view_word(view_word)
    );

    qrb_lane_mux #(
        .WORD_W(WORD_W),
        .BYTE_W(BYTE_W)
    ) u_mux (
        .word(view_word),
        .lane(lane),
        .kind(kind),
        .dout(host_dout)
    );

endmodule

// File: rtl/qrb_check.sv
module qrb_check #(
    parameter int REG_COUNT   = 64,
    parameter int WORD_W      = 32,
    parameter int BYTE_W      = 8,
    parameter int AUTO_UPDATE = 0,
    localparam int IDX_W      = $clog2(REG_COUNT),
    localparam int LANE_N     = WORD_W / BYTE_W,
    localparam int LANE_W     = $clog2(LANE_N),
    localparam int ADDR_W     = IDX_W + LANE_W + 1
) (
    input logic                        clk,
    input logic                        rst,
    input logic [ADDR_W-1:0]           host_addr,
    input logic                        host_rd,
    input logic [REG_COUNT*WORD_W-1:0] core_regs,
    input logic [BYTE_W-1:0]           host_dout,
    input logic [WORD_W-1:0]           shadow_q
);

    logic [LANE_W-1:0] c_lane;
    logic [IDX_W-1:0]  c_idx;
    logic              c_cap;
    logic [WORD_W-1:0] c_live;
    logic [BYTE_W-1:0] c_live_byte;
    logic [BYTE_W-1:0] c_shadow_byte;
    logic              rst_d;

    assign c_lane = host_addr[LANE_W-1:0];
    assign c_idx  = host_addr[LANE_W +: IDX_W];
    assign c_cap  = host_rd && (host_addr[ADDR_W-1] ||
                    ((AUTO_UPDATE != 0) && (c_lane == '0)));
    assign c_live = core_regs[c_idx*WORD_W +: WORD_W];
    assign c_live_byte   = BYTE_W'(c_live >> ((LANE_N-1-int'(c_lane))*BYTE_W));
    assign c_shadow_byte = BYTE_W'(shadow_q >> ((LANE_N-1-int'(c_lane))*BYTE_W));

    always_ff @(posedge clk) rst_d <= rst;

    always_ff @(posedge clk) begin
        if (rst_d === 1'b1) begin
            AST_RESET_CLEAR: assert (shadow_q == '0); // R1
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !host_rd |-> host_dout == '0); // R2

    AST_SNAP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        c_cap |=> shadow_q == $past(c_live)); // R3

    AST_LIVE_BYPASS: assert property (@(posedge clk) disable iff (rst)
        c_cap |-> host_dout == c_live_byte); // R3

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
        !c_cap |=> $stable(shadow_q)); // R7

    AST_LANE_FROM_SHADOW: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !c_cap) |-> host_dout == c_shadow_byte); // R5

endmodule

bind quad_read_bridge qrb_check #(
    .REG_COUNT  (REG_COUNT),
    .WORD_W     (WORD_W),
    .BYTE_W     (BYTE_W),
    .AUTO_UPDATE(AUTO_UPDATE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .host_addr(host_addr),
    .host_rd  (host_rd),
    .core_regs(core_regs),
    .host_dout(host_dout),
    .shadow_q (shadow_q)
);

// File: tb/sim_quad_read_bridge.sv
`timescale 1ns/1ps
module sim_quad_read_bridge;

    localparam int NREG = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [8:0]        host_addr = '0;
    logic              host_rd = 1'b0;
    logic [NREG*32-1:0] core_regs;
    logic [7:0]        dout0, dout1;
    logic [31:0]       live [NREG];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_sh0 = '0;
    logic [31:0] m_sh1 = '0;
    logic [7:0]  exp0_q [$];
    logic [7:0]  exp1_q [$];
    string       tag_q  [$];

    always #4 clk = ~clk;

    quad_read_bridge #(.AUTO_UPDATE(0)) u0 (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
        .core_regs(core_regs), .host_dout(dout0));

    quad_read_bridge #(.AUTO_UPDATE(1)) u1 (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
        .core_regs(core_regs), .host_dout(dout1));

    always @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) live[i] <= 32'h1122_3344 ^ (i * 32'h0101_0101);
            else     live[i] <= live[i] + (i + 1) * 32'h0103_0507;
        end
    end

    always_comb begin
        for (int i = 0; i < NREG; i++) core_regs[i*32 +: 32] = live[i];
    end

    function automatic logic [7:0] lane_of(logic [31:0] w, logic [1:0] l);
        return w[31 - 8*l -: 8];
    endfunction

    // driver: applies one host cycle and pushes the expected bytes
    task automatic step(input logic rd, input logic [8:0] a, input string tag);
        logic [5:0]  idx;
        logic [1:0]  ln;
        logic        c0, c1;
        logic [31:0] v0, v1;
        @(negedge clk);
        host_rd   = rd;
        host_addr = a;
        idx = a[7:2];
        ln  = a[1:0];
        c0  = rd && a[8];
        c1  = rd && (a[8] || ln == 2'd0);
        v0  = c0 ? live[idx] : m_sh0;
        v1  = c1 ? live[idx] : m_sh1;
        exp0_q.push_back(rd ? lane_of(v0, ln) : 8'h00);
        exp1_q.push_back(rd ? lane_of(v1, ln) : 8'h00);
        tag_q.push_back(tag);
        if (c0) m_sh0 = live[idx];
        if (c1) m_sh1 = live[idx];
    endtask

    // monitor: compares each cycle's outputs just before the capturing edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (tag_q.size() != 0) begin
                logic [7:0] e0, e1;
                string t;
                e0 = exp0_q.pop_front();
                e1 = exp1_q.pop_front();
                t  = tag_q.pop_front();
                checks += 2;
                if (dout0 !== e0) begin
                    errors++;
                    $display("FAIL %s u0 actual %02h expected %02h", t, dout0, e0);
                end
                if (dout1 !== e1) begin
                    errors++;
                    $display("FAIL %s u1 actual %02h expected %02h", t, dout1, e1);
                end
            end
        end
    end

    function automatic logic [8:0] ha(logic upd, logic [5:0] idx, logic [1:0] ln);
        return {upd, idx, ln};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1/R2 reset state and idle output
        step(1'b0, ha(1'b0, 6'd5, 2'd0), "R2 idle after reset");
        step(1'b0, ha(1'b1, 6'd5, 2'd1), "R2 request without read");
        for (int l = 1; l < 4; l++) step(1'b1, ha(1'b0, 6'd5, 2'(l)), "R1 cleared shadow");
        // R3 capture with same-cycle bypass, then R4/R6 lane readout
        step(1'b1, ha(1'b1, 6'd5, 2'd1), "R3 capture reg 5");
        for (int l = 0; l < 4; l++) step(1'b1, ha(1'b0, 6'd5, 2'(l)), "R4 R6 lane order");
        // R5 R7 any order, repeats, foreign index bits
        step(1'b1, ha(1'b0, 6'd40, 2'd3), "R7 foreign index");
        step(1'b1, ha(1'b0, 6'd5, 2'd1), "R5 lane change");
        step(1'b1, ha(1'b0, 6'd9, 2'd3), "R7 repeat");
        step(1'b1, ha(1'b0, 6'd5, 2'd2), "R5 lane change");
        step(1'b0, ha(1'b0, 6'd5, 2'd2), "R2 idle gap");
        step(1'b1, ha(1'b0, 6'd63, 2'd2), "R7 after gap");
        // R8 single byte address 0x156
        step(1'b1, 9'h156, "R8 address 0x156");
        for (int l = 3; l >= 0; l--) step(1'b1, ha(1'b0, 6'd21, 2'(l)), "R8 R6 reg 21 readout");
        // R10 held request re-captures each cycle
        for (int k = 0; k < 4; k++) step(1'b1, ha(1'b1, 6'd63, 2'(k)), "R10 held request");
        step(1'b1, ha(1'b0, 6'd63, 2'd3), "R10 last snapshot kept");
        // R9 auto update on lane 0 (u1 only)
        step(1'b1, ha(1'b0, 6'd12, 2'd0), "R9 lane0 read");
        step(1'b1, ha(1'b0, 6'd12, 2'd2), "R9 lane2 no capture");
        step(1'b1, ha(1'b0, 6'd30, 2'd3), "R9 other lane");
        step(1'b1, ha(1'b0, 6'd30, 2'd0), "R9 lane0 new reg");
        step(1'b1, ha(1'b0, 6'd30, 2'd1), "R9 readout");
        // highest register, lane 3 boundary
        step(1'b1, ha(1'b1, 6'd63, 2'd3), "R3 R4 top register lane 3");
        step(1'b1, ha(1'b0, 6'd0, 2'd0), "R4 R6 lane 0 after");
        step(1'b0, ha(1'b1, 6'd0, 2'd0), "R2 final idle");
        repeat (3) @(negedge clk);
        #3;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule